// File: doc/BRIEF.md
# Dual-Word Numerically Controlled Oscillator with Phase Offset

This block is the numeric core of a direct digital synthesis engine. A wide phase accumulator advances once per clock by a frequency tuning word. A phase offset is added to the upper bits of that accumulator, and the resulting phase word is turned into a 10-bit waveform sample (sine or triangle) and a one-bit square wave.

Two tuning words and two offset words are held in the block and loaded through plain parallel write ports. Two select inputs choose the active tuning word and the active offset, and either can change on any cycle. This gives frequency-shift and phase-shift keying with no reload delay. A sleep input holds the accumulator still. A synchronous reset returns the accumulator and outputs to a known state but keeps every loaded word.

Top module: `nco_dual_core`

## Requirements
- R1: A clock edge with `rst` high clears the accumulator, drives `wave_out` to mid-scale 512 and drives `square_out` to 0. This happens even when `sleep` is also high.
- R2: A write with `fw_en`/`pw_en` high stores the word into slot `fw_slot`/`pw_slot` (0 or 1) at that edge. Stored words survive reset. A write and a select change in the same cycle both take effect at that edge: the accumulator update at that edge uses the word held before it.
- R3: On each edge with `rst` and `sleep` low, the 28-bit accumulator adds the tuning word in slot `freq_pick`, wrapping modulo 2^28.
- R4: The phase word is accumulator bits [27:16] plus the offset in slot `phase_pick`, modulo 4096. The lower 16 accumulator bits are dropped.
- R5: With `tri_mode` low and phase p, let q = p[11:10], i = p[9:0], and j = i when q[0] is 0, otherwise 1023 - i. Let A(j) = round(511·sin(π(j+0.5)/2048)). The sample is 512 + A(j) for q[1] = 0 and 511 - A(j) for q[1] = 1.
- R6: With `tri_mode` high, the sample is p[10:1] when p[11] is 0 and (~p)[10:1] when p[11] is 1. It rises from 0 to 1023 over the first half of the phase circle and falls back over the second half.
- R7: With `sq_half` low, `square_out` is bit 11 of the phase word. With `sq_half` high, `square_out` toggles on every 0-to-1 transition of that bit.
- R8: While `sleep` is high (and `rst` low), the accumulator holds its value. Offset and mode changes still reach the outputs.
- R9: The phase word is registered one edge after the accumulator, and the outputs are registered one edge after the phase word. The accumulator value present before edge n therefore appears in the outputs after edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Holds the accumulator when high |
| fw_en | input | 1 | Tuning-word write strobe |
| fw_slot | input | 1 | Tuning-word slot written |
| fw_word | input | 28 | Tuning-word write data |
| pw_en | input | 1 | Offset write strobe |
| pw_slot | input | 1 | Offset slot written |
| pw_word | input | 12 | Offset write data |
| freq_pick | input | 1 | Active tuning-word slot |
| phase_pick | input | 1 | Active offset slot |
| tri_mode | input | 1 | 1 = triangle, 0 = sine |
| sq_half | input | 1 | 1 = square at half the phase-MSB rate |
| wave_out | output | 10 | Offset-binary waveform sample |
| square_out | output | 1 | Square-wave output |

## Verification
Reset and sleep can be high in the same cycle, and reset must win. The bench holds `sleep` high on a running accumulator and then raises `rst` for one edge. It judges the result by mid-scale output and by the model's zero-phase output sequence that follows. A tuning-word write to the active slot can also coincide with a `freq_pick` switch in the same cycle. This is provoked mid-sweep, and the cycle-exact reference model judges that the old word is added at that edge and the new one afterwards.

// File: rtl/nco_pkg.sv
package nco_pkg;

   typedef enum logic {
      SHAPE_SINE = 1'b0,
      SHAPE_TRI  = 1'b1
   } shape_e;

   localparam real PI_R = 3.14159265358979323846;

   // Quarter-wave magnitude at the centre of bin j, scaled to amp, by series.
   function automatic int quarter_amp(int j, int depth, int amp);
      real x;
      real term;
      real sum;
      x    = PI_R * (real'(j) + 0.5) / (2.0 * real'(depth));
      term = x;
      sum  = x;
      for (int k = 1; k <= 10; k++) begin
         term = -term * x * x / real'((2 * k) * (2 * k + 1));
         sum  = sum + term;
      end
      return $rtoi(real'(amp) * sum + 0.5);
   endfunction

endpackage

// File: rtl/nco_word_bank.sv
module nco_word_bank #(
   parameter  int W     = 28,
   parameter  int SLOTS = 2,
   localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [SW-1:0] wr_slot,
   input  logic [W-1:0]  wr_data,
   input  logic [SW-1:0] rd_slot,
   output logic [W-1:0]  rd_data
);

   logic [W-1:0] words [SLOTS];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_slot == SW'(s))) begin
            q <= wr_data;
         end
      end
      assign words[s] = q;
   end

   assign rd_data = words[rd_slot];

endmodule

// File: rtl/nco_phase_path.sv
module nco_phase_path #(
   parameter int ACC_W   = 28,
   parameter int PHASE_W = 12
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sleep,
   input  logic [ACC_W-1:0]   step,
   input  logic [PHASE_W-1:0] offset,
   output logic [ACC_W-1:0]   acc_o,
   output logic [PHASE_W-1:0] phase_o
);

   logic [ACC_W-1:0]   acc_r;
   logic [PHASE_W-1:0] phase_r;
   logic [PHASE_W-1:0] acc_top;

   assign acc_top = acc_r[ACC_W-1 -: PHASE_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_r <= '0;
      end else if (!sleep) begin
         acc_r <= acc_r + step;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_r <= '0;
      end else begin
         phase_r <= acc_top + offset;
      end
   end

   assign acc_o   = acc_r;
   assign phase_o = phase_r;

endmodule

// File: rtl/nco_wave_shaper.sv
module nco_wave_shaper #(
   parameter  int PHASE_W = 12,
   parameter  int OUT_W   = 10,
   localparam int LUT_W   = PHASE_W - 2,
   localparam int LUT_D   = 1 << LUT_W,
   localparam int AMP     = (1 << (OUT_W - 1)) - 1
) (
   input  logic               clk,
   input  logic               rst,
   input  nco_pkg::shape_e    shape,
   input  logic [PHASE_W-1:0] phase,
   output logic [OUT_W-1:0]   wave
);

   localparam logic [OUT_W-1:0] MID_V = {1'b1, {(OUT_W-1){1'b0}}};
   localparam logic [OUT_W-1:0] LOW_V = MID_V - 1'b1;

   logic [OUT_W-2:0] quarter [LUT_D];

   for (genvar j = 0; j < LUT_D; j++) begin : g_lut
      localparam int MAG = nco_pkg::quarter_amp(j, LUT_D, AMP);
      assign quarter[j] = (OUT_W-1)'(MAG);
   end

   logic [1:0]         quad;
   logic [LUT_W-1:0]   idx;
   logic [LUT_W-1:0]   addr;
   logic [OUT_W-1:0]   mag;
   logic [OUT_W-1:0]   sine_v;
   logic [PHASE_W-2:0] fold;
   logic [OUT_W-1:0]   tri_v;

   assign quad   = phase[PHASE_W-1 -: 2];
   assign idx    = phase[LUT_W-1:0];
   assign addr   = quad[0] ? ~idx : idx;
   assign mag    = {1'b0, quarter[addr]};
   assign sine_v = quad[1] ? (LOW_V - mag) : (MID_V + mag);

   assign fold   = phase[PHASE_W-1] ? ~phase[PHASE_W-2:0] : phase[PHASE_W-2:0];
   assign tri_v  = fold[PHASE_W-2 -: OUT_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         wave <= MID_V;
      end else if (shape == nco_pkg::SHAPE_TRI) begin
         wave <= tri_v;
      end else begin
         wave <= sine_v;
      end
   end

endmodule

// File: rtl/nco_square_gen.sv
module nco_square_gen (
   input  logic clk,
   input  logic rst,
   input  logic msb_in,
   input  logic half_sel,
   output logic msb_q,
   output logic sq
);

   logic tog_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         msb_q <= 1'b0;
         tog_q <= 1'b0;
      end else begin
         msb_q <= msb_in;
         if (msb_in && !msb_q) begin
            tog_q <= ~tog_q;
         end
      end
   end

   assign sq = half_sel ? tog_q : msb_q;

endmodule

// File: rtl/nco_dual_core.sv
module nco_dual_core #(
   parameter int ACC_W   = 28,
   parameter int PHASE_W = 12,
   parameter int OUT_W   = 10
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sleep,
   input  logic               fw_en,
   input  logic               fw_slot,
   input  logic [ACC_W-1:0]   fw_word,
   input  logic               pw_en,
   input  logic               pw_slot,
   input  logic [PHASE_W-1:0] pw_word,
   input  logic               freq_pick,
   input  logic               phase_pick,
   input  logic               tri_mode,
   input  logic               sq_half,
   output logic [OUT_W-1:0]   wave_out,
   output logic               square_out
);

   if (PHASE_W > ACC_W) begin : g_bad_acc
      $error("PHASE_W must not exceed ACC_W");
   end
   if (PHASE_W < 3 || PHASE_W > 14) begin : g_bad_phase
      $error("PHASE_W must lie in 3..14");
   end
   if (OUT_W < 2 || OUT_W > PHASE_W - 1) begin : g_bad_out
      $error("OUT_W must lie in 2..PHASE_W-1");
   end

   logic [ACC_W-1:0]   step_w;
   logic [PHASE_W-1:0] offset_w;
   logic [ACC_W-1:0]   acc_q;
   logic [PHASE_W-1:0] phase_q;
   logic               msb_q;
   nco_pkg::shape_e    shape_w;

   assign shape_w = tri_mode ? nco_pkg::SHAPE_TRI : nco_pkg::SHAPE_SINE;

   nco_word_bank #(.W(ACC_W), .SLOTS(2)) u_freq_bank (
      .clk     (clk),
      .wr_en   (fw_en),
      .wr_slot (fw_slot),
      .wr_data (fw_word),
      .rd_slot (freq_pick),
      .rd_data (step_w)
   );

   nco_word_bank #(.W(PHASE_W), .SLOTS(2)) u_phase_bank (
      .clk     (clk),
      .wr_en   (pw_en),
      .wr_slot (pw_slot),
      .wr_data (pw_word),
      .rd_slot (phase_pick),
      .rd_data (offset_w)
   );

   nco_phase_path #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_path (
      .clk     (clk),
      .rst     (rst),
      .sleep   (sleep),
      .step    (step_w),
      .offset  (offset_w),
      .acc_o   (acc_q),
      .phase_o (phase_q)
   );

   nco_wave_shaper #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_shape (
      .clk   (clk),
      .rst   (rst),
      .shape (shape_w),
      .phase (phase_q),
      .wave  (wave_out)
   );

   nco_square_gen u_square (
      .clk      (clk),
      .rst      (rst),
      .msb_in   (phase_q[PHASE_W-1]),
      .half_sel (sq_half),
      .msb_q    (msb_q),
      .sq       (square_out)
   );

endmodule

// File: rtl/nco_dual_core_chk.sv
module nco_dual_core_chk #(
   parameter int ACC_W = 28,
   parameter int OUT_W = 10
) (
   input logic             clk,
   input logic             rst,
   input logic             sleep,
   input logic             sq_half,
   input logic             square_out,
   input logic [OUT_W-1:0] wave_out,
   input logic [ACC_W-1:0] acc,
   input logic             msb
);

   localparam logic [OUT_W-1:0] MID_V = {1'b1, {(OUT_W-1){1'b0}}};

   logic armed;
   always_ff @(posedge clk) armed <= 1'b1;

   // R1
   reset_mid_chk: assert property (@(posedge clk) disable iff (!armed)
      $past(rst) |-> (wave_out == MID_V && !square_out));

   // R1
   reset_acc_chk: assert property (@(posedge clk) disable iff (!armed)
      $past(rst) |-> (acc == '0));

   // R8
   sleep_hold_chk: assert property (@(posedge clk) disable iff (!armed || rst)
      sleep |=> $stable(acc));

   // R7
   half_only_on_rise_chk: assert property (@(posedge clk) disable iff (!armed || rst)
      (sq_half && $past(sq_half) && !$past(rst) && (square_out != $past(square_out)))
      |-> $rose(msb));

   // R7
   half_flips_on_rise_chk: assert property (@(posedge clk) disable iff (!armed || rst)
      (sq_half && $past(sq_half) && !$past(rst) && $rose(msb))
      |-> (square_out != $past(square_out)));

endmodule

bind nco_dual_core nco_dual_core_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .sleep      (sleep),
   .sq_half    (sq_half),
   .square_out (square_out),
   .wave_out   (wave_out),
   .acc        (acc_q),
   .msb        (msb_q)
);

// File: tb/test_nco_dual_core.sv
`timescale 1ns/1ps
module test_nco_dual_core;

   localparam real PI_R = 3.14159265358979323846;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sleep = 1'b0;
   logic        fw_en = 1'b0;
   logic        fw_slot = 1'b0;
   logic [27:0] fw_word = '0;
   logic        pw_en = 1'b0;
   logic        pw_slot = 1'b0;
   logic [11:0] pw_word = '0;
   logic        freq_pick = 1'b0;
   logic        phase_pick = 1'b0;
   logic        tri_mode = 1'b0;
   logic        sq_half = 1'b0;
   logic [9:0]  wave_out;
   logic        square_out;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   nco_dual_core i_nco_dual_core (
      .clk(clk), .rst(rst), .sleep(sleep),
      .fw_en(fw_en), .fw_slot(fw_slot), .fw_word(fw_word),
      .pw_en(pw_en), .pw_slot(pw_slot), .pw_word(pw_word),
      .freq_pick(freq_pick), .phase_pick(phase_pick),
      .tri_mode(tri_mode), .sq_half(sq_half),
      .wave_out(wave_out), .square_out(square_out)
   );

   function automatic int sine_ref(int p);
      int q, i, j, a;
      q = (p >> 10) & 3;
      i = p & 1023;
      j = (q & 1) ? 1023 - i : i;
      a = $rtoi(511.0 * $sin(PI_R * (real'(j) + 0.5) / 2048.0) + 0.5);
      return (q & 2) ? 511 - a : 512 + a;
   endfunction

   function automatic int tri_ref(int p);
      return (p < 2048) ? (p >> 1) : ((4095 - p) >> 1);
   endfunction

   // Cycle reference built from R1..R9
   logic [27:0] fm [2];
   logic [11:0] pm [2];
   logic [27:0] am;
   logic [11:0] qm;
   int          om;
   logic        mm, tm;

   always @(posedge clk) begin
      if (fw_en) fm[fw_slot] <= fw_word;
      if (pw_en) pm[pw_slot] <= pw_word;
      if (rst) begin
         am <= '0; qm <= '0; om <= 512; mm <= 1'b0; tm <= 1'b0;
      end else begin
         if (!sleep) am <= am + fm[freq_pick];
         qm <= am[27:16] + pm[phase_pick];
         om <= tri_mode ? tri_ref(int'(qm)) : sine_ref(int'(qm));
         mm <= qm[11];
         if (qm[11] && !mm) tm <= ~tm;
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(string tag, bit chk);
      @(posedge clk);
      #2;
      if (chk) begin
         check({tag, " wave"}, int'(wave_out), om);
         check({tag, " square"}, int'(square_out), int'(sq_half ? tm : mm));
      end
   endtask

   task automatic wr_f(bit s, logic [27:0] w);
      fw_en = 1'b1; fw_slot = s; fw_word = w;
   endtask

   task automatic wr_p(bit s, logic [11:0] w);
      pw_en = 1'b1; pw_slot = s; pw_word = w;
   endtask

   task automatic wr_off();
      fw_en = 1'b0; pw_en = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int hold;
      // R2: load all slots while reset is held
      #2;
      wr_f(1'b0, 28'h001_0000);
      cyc("R2", 1'b0);
      wr_f(1'b1, 28'h003_1234);
      cyc("R2", 1'b0);
      wr_off();
      wr_p(1'b0, 12'h000);
      cyc("R2", 1'b0);
      wr_p(1'b1, 12'h400);
      cyc("R2", 1'b0);
      wr_off();
      cyc("R1", 1'b0);
      check("R1 reset wave", int'(wave_out), 512);
      check("R1 reset square", int'(square_out), 0);

      // R9 explicit latency with triangle, step 1 phase unit per clock
      tri_mode = 1'b1;
      rst = 1'b0;
      for (int n = 1; n <= 8; n++) begin
         cyc("R9", 1'b0);
         check("R9 latency", int'(wave_out), tri_ref(n >= 2 ? n - 2 : 0));
      end
      // R6 full triangle sweep
      for (int n = 0; n < 4200; n++) cyc("R6", 1'b1);

      // R5 full sine sweep from reset
      tri_mode = 1'b0;
      rst = 1'b1;
      cyc("R1", 1'b1);
      rst = 1'b0;
      for (int n = 0; n < 4200; n++) cyc("R5", 1'b1);

      // R3 frequency keying
      for (int n = 0; n < 600; n++) begin
         if (n % 37 == 0) freq_pick = ~freq_pick;
         cyc("R3", 1'b1);
      end

      // R4 phase keying, both shapes
      for (int n = 0; n < 400; n++) begin
         if (n % 23 == 0) phase_pick = ~phase_pick;
         if (n == 200) tri_mode = 1'b1;
         cyc("R4", 1'b1);
      end
      tri_mode = 1'b0;

      // R8 sleep: output holds when nothing else changes
      sleep = 1'b1;
      cyc("R8", 1'b1);
      cyc("R8", 1'b1);
      cyc("R8", 1'b1);
      hold = int'(wave_out);
      for (int n = 0; n < 20; n++) begin
         cyc("R8", 1'b1);
         check("R8 frozen", int'(wave_out), hold);
      end
      // R8 offset still reaches output while asleep
      for (int n = 0; n < 40; n++) begin
         if (n % 7 == 0) phase_pick = ~phase_pick;
         cyc("R8", 1'b1);
      end

      // R1 reset and sleep in the same cycle: reset wins
      rst = 1'b1;
      cyc("R1", 1'b1);
      check("R1 reset+sleep wave", int'(wave_out), 512);
      rst = 1'b0;
      sleep = 1'b0;
      phase_pick = 1'b0;
      freq_pick = 1'b0;
      for (int n = 1; n <= 6; n++) begin
         cyc("R1", 1'b1);
         check("R1 restart", int'(wave_out), sine_ref(n >= 2 ? n - 2 : 0));
      end

      // R2 write to the slot being switched to, in the same cycle
      for (int n = 0; n < 50; n++) cyc("R2", 1'b1);
      wr_f(1'b1, 28'h00A_5000);
      freq_pick = 1'b1;
      cyc("R2", 1'b1);
      wr_off();
      for (int n = 0; n < 100; n++) cyc("R2", 1'b1);

      // R7 square direct and halved, fast step
      wr_f(1'b0, 28'h100_0000);
      freq_pick = 1'b0;
      cyc("R7", 1'b1);
      wr_off();
      for (int n = 0; n < 100; n++) cyc("R7", 1'b1);
      sq_half = 1'b1;
      for (int n = 0; n < 200; n++) cyc("R7", 1'b1);
      tri_mode = 1'b1;
      for (int n = 0; n < 100; n++) cyc("R7", 1'b1);

      // R2 stored words survive reset
      rst = 1'b1;
      cyc("R2", 1'b1);
      rst = 1'b0;
      freq_pick = 1'b1;
      phase_pick = 1'b1;
      for (int n = 0; n < 300; n++) cyc("R2", 1'b1);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule